// File: doc/BRIEF.md
# Full-Search Block Motion Estimator

This block finds the motion vector for one 8x8 block of the current frame. It compares the block against every displaced position inside a square window of the previous reconstructed frame. A single write port fills two local stores: the current block and the reference window that surrounds it. After `start`, the block sweeps all 256 displacements. For each one it adds up the absolute pixel differences and keeps the displacement with the smallest total.

When the sweep is over, the block forms the prediction error: the current block minus the reference block at the winning displacement. It raises `done` for one cycle, with the vector and the 64 residual samples on its outputs. The residual then goes on to the transform stage, and the vector goes on to the coder.

The window is 23x23 pixels. A displacement (dx, dy), each from -8 to +7, lines up current pixel (r, c) with window pixel (r+dy+8, c+dx+8). A whole search takes a fixed number of cycles, whatever the picture content.

Top module: `me_full_search`

## Requirements
- R1: After reset, `done` is low, `mv_x` and `mv_y` read 0, and every residual sample reads 0.
- R2: With `wr_en` high, `wr_ref`=0 writes `wr_data` to current-block pixel (`wr_row`, `wr_col`), each 0..7. `wr_ref`=1 writes window pixel (`wr_row`, `wr_col`), each 0..22. Window pixel (r+dy+8, c+dx+8) faces current pixel (r, c) under displacement (dx, dy).
- R3: Every displacement with dx and dy in -8..+7 is scored. This holds for the corner positions (+7,+7) and (-8,-8).
- R4: The score of a displacement is the sum of the absolute differences of the 64 unsigned 8-bit pixel pairs. The displacement with the lowest score is selected.
- R5: When scores are equal, the displacement met first is kept. The scan order is dy outer and dx inner, each running from -8 up to +7.
- R6: `mv_x` carries dx and `mv_y` carries dy of the selected displacement. Both are 5-bit two's complement.
- R7: Residual sample k = r*8+c sits in `res_flat[k*9 +: 9]` as 9-bit two's complement. Its value is current(r,c) minus window(r+dy+8, c+dx+8) at the selected displacement.
- R8: `done` is high for exactly one cycle, 16449 clock edges after the edge that accepts `start`, counting that edge as the first. The residual outputs do not change while a sweep is running.
- R9: `start` has no effect while a search, the residual phase or the done cycle is in progress.
- R10: Totals up to 64*255 are kept without wrap-around. An all-255 block scored against an all-0 window still gives a correct selection and residual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| wr_en | input | 1 | Pixel write strobe |
| wr_ref | input | 1 | 0 selects current block, 1 selects reference window |
| wr_row | input | 5 | Row of the written pixel |
| wr_col | input | 5 | Column of the written pixel |
| wr_data | input | 8 | Unsigned pixel value |
| done | output | 1 | One-cycle result strobe |
| mv_x | output | 5 | Horizontal displacement, two's complement |
| mv_y | output | 5 | Vertical displacement, two's complement |
| res_flat | output | 576 | 64 residual samples, 9 bits each |

## Verification
The two events that can land in the same cycle are a new `start` request and a search that is already running, including its residual phase and its done cycle. The bench raises `start` in the middle of the sweep and again during the residual phase. It checks that `done` still arrives at exactly the cycle the first request predicts, and only once. It also holds `start` high during the `done` cycle itself. It then watches for longer than a full search to confirm that no second result ever appears and that the vector outputs stay unchanged.

// File: rtl/me_pkg.sv
// Package: shared types of the block motion estimator.
// Assumes nothing beyond IEEE 1800-2017 enums.
package me_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_RESID  = 2'd2,
        ST_DONE   = 2'd3
    } me_state_e;
endpackage

// File: rtl/me_scan_ctrl.sv
// Sequencer: steps the pixel and displacement counters through the sweep,
// then the residual pass, then a one-cycle done state.
// Assumes BLK and SPAN are powers of two.
module me_scan_ctrl
    import me_pkg::*;
#(
    parameter int BLK  = 8,
    parameter int SPAN = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output me_state_e                 state_o,
    output logic [$clog2(BLK)-1:0]    pix_r,
    output logic [$clog2(BLK)-1:0]    pix_c,
    output logic [$clog2(SPAN)-1:0]   dx_i,
    output logic [$clog2(SPAN)-1:0]   dy_i,
    output logic                      first_cand,
    output logic                      search_en,
    output logic                      score_en,
    output logic                      res_en,
    output logic                      done
);
    localparam int PW = $clog2(BLK);
    localparam int DW = $clog2(SPAN);

    me_state_e state_q;
    logic      last_pix;
    logic      last_cand;

    // Decode the ends of the pixel and displacement scans.
    always_comb begin
        last_pix   = (pix_r == PW'(BLK - 1)) && (pix_c == PW'(BLK - 1));
        last_cand  = (dx_i == DW'(SPAN - 1)) && (dy_i == DW'(SPAN - 1));
        first_cand = (dx_i == '0) && (dy_i == '0);
        search_en  = (state_q == ST_SEARCH);
        score_en   = search_en && last_pix;
        res_en     = (state_q == ST_RESID);
        done       = (state_q == ST_DONE);
        state_o    = state_q;
    end

    // State and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pix_r   <= '0;
            pix_c   <= '0;
            dx_i    <= '0;
            dy_i    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SEARCH;
                        pix_r   <= '0;
                        pix_c   <= '0;
                        dx_i    <= '0;
                        dy_i    <= '0;
                    end
                end
                ST_SEARCH, ST_RESID: begin
                    if (pix_c == PW'(BLK - 1)) begin
                        pix_c <= '0;
                        pix_r <= (pix_r == PW'(BLK - 1)) ? '0 : pix_r + 1'b1;
                    end else begin
                        pix_c <= pix_c + 1'b1;
                    end
                    if (state_q == ST_SEARCH && last_pix) begin
                        if (dx_i == DW'(SPAN - 1)) begin
                            dx_i <= '0;
                            dy_i <= (dy_i == DW'(SPAN - 1)) ? '0 : dy_i + 1'b1;
                        end else begin
                            dx_i <= dx_i + 1'b1;
                        end
                        if (last_cand) state_q <= ST_RESID;
                    end
                    if (state_q == ST_RESID && last_pix) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=>
        !(state_q == ST_SEARCH && first_cand && pix_r == '0 && pix_c == '0)); // R9
endmodule

// File: rtl/me_sad_acc.sv
// Distortion accumulator: adds one absolute pixel difference per cycle.
// `first` restarts the total; `total` already includes the current pair.
module me_sad_acc #(
    parameter int PIX_W   = 8,
    parameter int SUM_W   = 14,
    parameter int MAX_SUM = 16320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [SUM_W-1:0] total
);
    logic [SUM_W-1:0] acc_q;
    logic [PIX_W-1:0] diff;

    // Absolute difference and running total.
    always_comb begin
        diff  = (a > b) ? (a - b) : (b - a);
        total = (first ? '0 : acc_q) + SUM_W'(diff);
    end

    // Hold the partial total between pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= total;
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= SUM_W'(MAX_SUM)); // R10
endmodule

// File: rtl/me_best_keep.sv
// Minimum tracker: stores the lowest score seen so far and its displacement.
// A strict comparison keeps the earliest of equal scores. The first candidate
// of a sweep is always taken.
module me_best_keep #(
    parameter int SUM_W   = 14,
    parameter int DW      = 4,
    parameter int RST_IDX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic [SUM_W-1:0] sad,
    input  logic [DW-1:0]    dx_i,
    input  logic [DW-1:0]    dy_i,
    output logic [DW-1:0]    best_dx,
    output logic [DW-1:0]    best_dy
);
    logic [SUM_W-1:0] best_sad;

    // Replace the stored best on a strictly lower score.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_sad <= '1;
            best_dx  <= DW'(RST_IDX);
            best_dy  <= DW'(RST_IDX);
        end else if (en && (first || sad < best_sad)) begin
            best_sad <= sad;
            best_dx  <= dx_i;
            best_dy  <= dy_i;
        end
    end

    AST_BEST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first) |=> best_sad <= $past(best_sad)); // R4
endmodule

// File: rtl/me_full_search.sv
// Full-search block motion estimator: holds one current block and its
// reference window, scores every displacement by SAD, keeps the minimum,
// then writes the residual block and pulses done.
// Assumes BLK and 2*RANGE are powers of two; pixels are unsigned.
module me_full_search
    import me_pkg::*;
#(
    parameter int BLK   = 8,
    parameter int RANGE = 8,
    parameter int PIX_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic                                  wr_en,
    input  logic                                  wr_ref,
    input  logic [$clog2(BLK+2*RANGE-1)-1:0]      wr_row,
    input  logic [$clog2(BLK+2*RANGE-1)-1:0]      wr_col,
    input  logic [PIX_W-1:0]                      wr_data,
    output logic                                  done,
    output logic [$clog2(2*RANGE):0]              mv_x,
    output logic [$clog2(2*RANGE):0]              mv_y,
    output logic [BLK*BLK*(PIX_W+1)-1:0]          res_flat
);
    localparam int SPAN    = 2 * RANGE;
    localparam int WIN     = BLK + SPAN - 1;
    localparam int RW      = $clog2(WIN);
    localparam int DW      = $clog2(SPAN);
    localparam int PW      = $clog2(BLK);
    localparam int NPIX    = BLK * BLK;
    localparam int CA_W    = $clog2(NPIX);
    localparam int RA_W    = $clog2(WIN * WIN);
    localparam int RES_W   = PIX_W + 1;
    localparam int MAX_SUM = NPIX * ((1 << PIX_W) - 1);
    localparam int SUM_W   = $clog2(MAX_SUM + 1);
    localparam int MV_W    = DW + 1;

    logic [PIX_W-1:0]        cur_mem [NPIX];
    logic [PIX_W-1:0]        ref_mem [WIN*WIN];
    logic signed [RES_W-1:0] res_q   [NPIX];

    me_state_e       state;
    logic [PW-1:0]   pix_r, pix_c;
    logic [DW-1:0]   dx_i, dy_i, best_dx, best_dy, off_x, off_y;
    logic            first_cand, search_en, score_en, res_en, pix_first;
    logic [RW-1:0]   ref_row, ref_col;
    logic [CA_W-1:0] cur_addr, wr_cur_addr;
    logic [RA_W-1:0] ref_addr, wr_ref_addr;
    logic [PIX_W-1:0] cur_pix, ref_pix;
    logic [SUM_W-1:0] sad_total;

    me_scan_ctrl #(.BLK(BLK), .SPAN(SPAN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .state_o(state),
        .pix_r(pix_r), .pix_c(pix_c), .dx_i(dx_i), .dy_i(dy_i),
        .first_cand(first_cand), .search_en(search_en), .score_en(score_en),
        .res_en(res_en), .done(done)
    );

    // Read addressing: sweep displacement while searching, winner afterwards.
    always_comb begin
        off_x     = res_en ? best_dx : dx_i;
        off_y     = res_en ? best_dy : dy_i;
        ref_row   = RW'(pix_r) + RW'(off_y);
        ref_col   = RW'(pix_c) + RW'(off_x);
        cur_addr  = CA_W'(pix_r) * CA_W'(BLK) + CA_W'(pix_c);
        ref_addr  = RA_W'(ref_row) * RA_W'(WIN) + RA_W'(ref_col);
        cur_pix   = cur_mem[cur_addr];
        ref_pix   = ref_mem[ref_addr];
        pix_first = (pix_r == '0) && (pix_c == '0);
        wr_cur_addr = CA_W'(wr_row) * CA_W'(BLK) + CA_W'(wr_col);
        wr_ref_addr = RA_W'(wr_row) * RA_W'(WIN) + RA_W'(wr_col);
    end

    // Pixel store writes from the load port.
    always_ff @(posedge clk) begin
        if (wr_en && !wr_ref && wr_row < RW'(BLK) && wr_col < RW'(BLK))
            cur_mem[wr_cur_addr] <= wr_data;
        if (wr_en && wr_ref && wr_row < RW'(WIN) && wr_col < RW'(WIN))
            ref_mem[wr_ref_addr] <= wr_data;
    end

    me_sad_acc #(.PIX_W(PIX_W), .SUM_W(SUM_W), .MAX_SUM(MAX_SUM)) u_sad (
        .clk(clk), .rst_n(rst_n), .en(search_en), .first(pix_first),
        .a(cur_pix), .b(ref_pix), .total(sad_total)
    );

    me_best_keep #(.SUM_W(SUM_W), .DW(DW), .RST_IDX(RANGE)) u_best (
        .clk(clk), .rst_n(rst_n), .en(score_en), .first(first_cand),
        .sad(sad_total), .dx_i(dx_i), .dy_i(dy_i),
        .best_dx(best_dx), .best_dy(best_dy)
    );

    // Residual pass: current minus matched reference, one sample per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NPIX; k++) res_q[k] <= '0;
        end else if (res_en) begin
            res_q[cur_addr] <= $signed({1'b0, cur_pix}) - $signed({1'b0, ref_pix});
        end
    end

    for (genvar g = 0; g < NPIX; g++) begin : g_res
        assign res_flat[g*RES_W +: RES_W] = res_q[g];
    end

    assign mv_x = MV_W'(best_dx) - MV_W'(RANGE);
    assign mv_y = MV_W'(best_dy) - MV_W'(RANGE);

    AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |=> $stable(res_flat)); // R8
endmodule

// File: tb/me_full_search_tb.sv
module me_full_search_tb;
    localparam int WIN     = 23;
    localparam int LATENCY = 256 * 64 + 64 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_ref = 1'b0;
    logic [4:0]  wr_row = '0;
    logic [4:0]  wr_col = '0;
    logic [7:0]  wr_data = '0;
    logic        done;
    logic [4:0]  mv_x, mv_y;
    logic [575:0] res_flat;

    int cur_m [8][8];
    int ref_m [WIN][WIN];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    me_full_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_ref(wr_ref), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .done(done), .mv_x(mv_x), .mv_y(mv_y), .res_flat(res_flat)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int r, input int c, input int seed);
        return (r * 29 + c * 71 + r * c * 17 + seed * 53 + (r ^ c) * 7) % 256;
    endfunction

    task automatic load_all();
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                wr_en = 1; wr_ref = 1; wr_row = 5'(r); wr_col = 5'(c);
                wr_data = 8'(ref_m[r][c]);
            end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                wr_en = 1; wr_ref = 0; wr_row = 5'(r); wr_col = 5'(c);
                wr_data = 8'(cur_m[r][c]);
            end
        @(negedge clk);
        wr_en = 0;
    endtask

    // Run one search; optionally pulse start mid-sweep and mid-residual (R9).
    task automatic run_and_check(input string name, input bit poke);
        int n;
        int best, bx, by, s;
        best = -1; bx = 0; by = 0;
        for (int dy = -8; dy < 8; dy++)
            for (int dx = -8; dx < 8; dx++) begin
                s = 0;
                for (int r = 0; r < 8; r++)
                    for (int c = 0; c < 8; c++) begin
                        int d;
                        d = cur_m[r][c] - ref_m[r+dy+8][c+dx+8];
                        s += (d < 0) ? -d : d;
                    end
                if (best < 0 || s < best) begin best = s; bx = dx; by = dy; end
            end
        @(negedge clk);
        start = 1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 0;
        while (!done && n < LATENCY + 50) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = poke && (n == 100 || n == 16420);
        end
        start = 0;
        $display("%s: mv=(%0d,%0d) sad=%0d", name, bx, by, best);
        check({name, " R8 done latency"}, n, LATENCY);
        check({name, " R3 R4 R6 mv_x"}, int'($signed(mv_x)), bx);
        check({name, " R5 R6 mv_y"}, int'($signed(mv_y)), by);
        begin
            int bad, first_bad_a, first_bad_e;
            bad = 0; first_bad_a = 0; first_bad_e = 0;
            for (int k = 0; k < 64; k++) begin
                int e, a;
                e = cur_m[k/8][k%8] - ref_m[k/8+by+8][k%8+bx+8];
                a = int'($signed(res_flat[k*9 +: 9]));
                if (a != e && bad == 0) begin first_bad_a = a; first_bad_e = e; end
                if (a != e) bad++;
            end
            check({name, " R7 residual"}, first_bad_a, first_bad_e);
        end
        @(negedge clk);
        check({name, " R8 single pulse"}, int'(done), 0);
    endtask

    task automatic t_reset();
        int nz;
        nz = 0;
        for (int k = 0; k < 64; k++) if (res_flat[k*9 +: 9] != 0) nz++;
        check("R1 done", int'(done), 0);
        check("R1 mv_x", int'(mv_x), 0);
        check("R1 mv_y", int'(mv_y), 0);
        check("R1 residual zero", nz, 0);
    endtask

    task automatic t_shift(input int seed, input int dx, input int dy, input string name);
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) ref_m[r][c] = pat(r, c, seed);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) cur_m[r][c] = ref_m[r+dy+8][c+dx+8];
        load_all();
        run_and_check(name, 0);
        check({name, " R2 R3 planted mv_x"}, int'($signed(mv_x)), dx);
        check({name, " R2 R3 planted mv_y"}, int'($signed(mv_y)), dy);
    endtask

    task automatic t_flat(input int cv, input int rv, input string name, input bit poke);
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) ref_m[r][c] = rv;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) cur_m[r][c] = cv;
        load_all();
        run_and_check(name, poke);
    endtask

    // R9: start held during the done cycle must not launch another search.
    task automatic t_start_at_done();
        int seen, hold_x;
        @(negedge clk);
        start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        hold_x = int'(mv_x);
        start = 1;
        @(negedge clk);
        start = 0;
        seen = 0;
        for (int i = 0; i < LATENCY + 20; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check("R9 start during done ignored", seen, 0);
        check("R9 vector unchanged", int'(mv_x), hold_x);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_shift(3, -5, 3, "shift");
        t_shift(11, 7, 7, "corner");
        t_flat(20, 50, "tie_flat", 0);
        t_flat(255, 0, "extreme_R10", 1);
        t_flat(0, 255, "negative_R10", 0);
        t_start_at_done();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule